// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

This block stands between a set of prioritised device request lines and the processor's status word. Each request line belongs to one priority level. The processor supplies its current execution priority and its interrupt-enable bit. The arbiter raises a single interrupt line when a device at a level strictly above the processor's priority is requesting and interrupts are enabled.

When the processor accepts the interrupt, the arbiter runs a short fixed sequence of status-word updates, one clock per step. It first writes the enable bit to 0. Next it latches the highest pending level that beats the processor's priority. Finally it writes that level into the priority field, writes the enable bit back to 1, and pulses a done flag with the level index so the processor can vector to the handler. Requests are level-sensitive: a device keeps its request pending until it drops the line. The processor owns the status word and applies the write strobes itself.

Top module: `prio_irq_arb`

## Requirements
- R1: While reset is high and in the first cycle after reset, `irq_o`, `ien_we_o`, `pri_we_o` and `done_o` are all 0.
- R2: In the idle state, `irq_o` is 1 one clock after the inputs present at least one request bit `req_i[l]` with level `l` strictly greater than `cpu_pri_i` and `ien_i` = 1. Otherwise it is 0.
- R3: Bit 0 of `req_i` never raises `irq_o` and is never reported as a granted level.
- R4: `ack_i` sampled while `irq_o` is 0 has no effect: no strobe and no done pulse follow.
- R5: One clock after `ack_i` is sampled with `irq_o` = 1, the mask step shows `ien_we_o` = 1, `ien_o` = 0, `pri_we_o` = 0 and `irq_o` = 0.
- R6: The identify step follows the mask step, and all strobes and `done_o` are 0 during it.
- R7: The grant step follows the identify step. In it, `pri_we_o` = 1, `ien_we_o` = 1, `ien_o` = 1 and `done_o` = 1, and `pri_o` and `done_lvl_o` carry the granted level. `done_o` lasts exactly one cycle.
- R8: The granted level is the highest level `l` > `cpu_pri_i` whose request bit is set at the identify edge.
- R9: If no qualifying request remains when the mask step ends, the next cycle shows `ien_we_o` = 1 and `ien_o` = 1, with no priority write and no done pulse, and the arbiter returns to idle.
- R10: `irq_o` stays 0 from the mask step until one clock after the arbiter returns to idle.
- R11: Requests stay pending while held. After the priority is raised to the granted level, the same held request does not interrupt again. When the priority is lowered, the held request raises `irq_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_LVL | Level-sensitive request per priority level |
| cpu_pri_i | input | LVL_W | Current processor priority |
| ien_i | input | 1 | Current interrupt-enable bit |
| ack_i | input | 1 | Processor accepts the interrupt |
| irq_o | output | 1 | Interrupt to the processor |
| ien_we_o | output | 1 | Write strobe for the enable bit |
| ien_o | output | 1 | Enable value to write |
| pri_we_o | output | 1 | Write strobe for the priority field |
| pri_o | output | LVL_W | Priority value to write |
| done_o | output | 1 | One-cycle pulse in the grant step |
| done_lvl_o | output | LVL_W | Granted level index |

## Verification
The bench builds the arbiter with its default of eight levels. This makes every one of the 256 request patterns reachable against all eight processor priorities and both enable values. For each combination it checks the interrupt decision and runs a full accept sequence whenever an interrupt is raised, with the expected level worked out arithmetically. It also checks ignored accepts, the abort path when a request drops during the mask step, and the re-raise of a held request after the priority is lowered.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_MASK  = 2'd1,
    S_FIND  = 2'd2,
    S_GRANT = 2'd3
  } arb_state_t;
endpackage

// File: rtl/prio_irq_qualify.sv
module prio_irq_qualify #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [LVL_W-1:0]   cpu_pri_i,
  output logic [NUM_LVL-1:0] elig_o
);
  // level 0 can never exceed any priority, so it is forced off
  assign elig_o[0] = 1'b0;
  for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
    assign elig_o[l] = req_i[l] && (LVL_W'(l) > cpu_pri_i);
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] elig_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   win_o
);
  always_comb begin
    win_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (elig_i[i]) win_o = LVL_W'(i);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/prio_irq_seq.sv
module prio_irq_seq
  import prio_irq_pkg::*;
#(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_i,
  input  logic [LVL_W-1:0] win_i,
  input  logic             ien_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             ien_we_o,
  output logic             ien_o,
  output logic             pri_we_o,
  output logic [LVL_W-1:0] pri_o,
  output logic             done_o,
  output logic [LVL_W-1:0] done_lvl_o
);
  arb_state_t       state;
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      irq_o      <= 1'b0;
      ien_we_o   <= 1'b0;
      ien_o      <= 1'b0;
      pri_we_o   <= 1'b0;
      pri_o      <= '0;
      done_o     <= 1'b0;
      done_lvl_o <= '0;
      lvl_q      <= '0;
    end else begin
      ien_we_o <= 1'b0;
      pri_we_o <= 1'b0;
      done_o   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ack_i && irq_o) begin
            state    <= S_MASK;
            irq_o    <= 1'b0;
            ien_we_o <= 1'b1;
            ien_o    <= 1'b0;
          end else begin
            irq_o <= any_i && ien_i;
          end
        end
        S_MASK: begin
          if (any_i) begin
            state <= S_FIND;
            lvl_q <= win_i;
          end else begin
            state    <= S_IDLE;
            ien_we_o <= 1'b1;
            ien_o    <= 1'b1;
          end
        end
        S_FIND: begin
          state      <= S_GRANT;
          pri_we_o   <= 1'b1;
          pri_o      <= lvl_q;
          ien_we_o   <= 1'b1;
          ien_o      <= 1'b1;
          done_o     <= 1'b1;
          done_lvl_o <= lvl_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> !irq_o);  // R10
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && ack_i && !irq_o) |=> (state == S_IDLE && !ien_we_o)); // R4
  AST_MASK_BEFORE_GRANT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(ien_we_o, 2) && !$past(ien_o, 2)));  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);  // R7
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (done_lvl_o != '0));  // R3
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [LVL_W-1:0]   cpu_pri_i,
  input  logic               ien_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic               ien_we_o,
  output logic               ien_o,
  output logic               pri_we_o,
  output logic [LVL_W-1:0]   pri_o,
  output logic               done_o,
  output logic [LVL_W-1:0]   done_lvl_o
);
  logic [NUM_LVL-1:0] elig;
  logic               any;
  logic [LVL_W-1:0]   win;

  prio_irq_qualify #(.NUM_LVL(NUM_LVL)) qual_i (
    .req_i(req_i), .cpu_pri_i(cpu_pri_i), .elig_o(elig));

  prio_irq_pick #(.NUM_LVL(NUM_LVL)) pick_i (
    .elig_i(elig), .any_o(any), .win_o(win));

  prio_irq_seq #(.NUM_LVL(NUM_LVL)) seq_i (
    .clk(clk), .rst(rst), .any_i(any), .win_i(win), .ien_i(ien_i),
    .ack_i(ack_i), .irq_o(irq_o), .ien_we_o(ien_we_o), .ien_o(ien_o),
    .pri_we_o(pri_we_o), .pri_o(pri_o), .done_o(done_o),
    .done_lvl_o(done_lvl_o));

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    any |-> elig[win]);  // R8
  AST_WIN_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    any |-> ((elig >> win) == NUM_LVL'(1)));  // R8
  AST_WIN_ABOVE: assert property (@(posedge clk) disable iff (rst)
    any |-> (win > cpu_pri_i));  // R2
endmodule

// File: tb/prio_irq_arb_tb_top.sv
`timescale 1ns/1ps
module prio_irq_arb_tb_top;
  localparam int NUM_LVL = 8;
  localparam int LVL_W = $clog2(NUM_LVL);

  logic clk = 1'b0;
  logic rst;
  logic [NUM_LVL-1:0] req_i;
  logic [LVL_W-1:0] cpu_pri_i;
  logic ien_i, ack_i;
  logic irq_o, ien_we_o, ien_o, pri_we_o, done_o;
  logic [LVL_W-1:0] pri_o, done_lvl_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  prio_irq_arb #(.NUM_LVL(NUM_LVL)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .cpu_pri_i(cpu_pri_i),
    .ien_i(ien_i), .ack_i(ack_i), .irq_o(irq_o), .ien_we_o(ien_we_o),
    .ien_o(ien_o), .pri_we_o(pri_we_o), .pri_o(pri_o), .done_o(done_o),
    .done_lvl_o(done_lvl_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int best_lvl(input int req, input int pri);
    best_lvl = -1;
    for (int l = NUM_LVL - 1; l > pri; l--)
      if (best_lvl < 0 && ((req >> l) & 1) != 0) best_lvl = l;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst = 1'b1; req_i = '0; cpu_pri_i = '0; ien_i = 1'b0; ack_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!irq_o && !ien_we_o && !pri_we_o && !done_o, "R1 reset", irq_o, 0);
    req_i = '1; ien_i = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    req_i = '0;
    @(negedge clk);
    chk(!irq_o && !ien_we_o && !pri_we_o && !done_o, "R1 after reset", irq_o, 0);

    for (int en = 0; en < 2; en++)
      for (int p = 0; p < NUM_LVL; p++)
        for (int r = 0; r < (1 << NUM_LVL); r++) begin
          int lvl;
          bit exp_irq;
          lvl = best_lvl(r, p);
          exp_irq = (lvl > 0) && (en == 1);
          req_i = NUM_LVL'(r); cpu_pri_i = LVL_W'(p); ien_i = en[0];
          @(negedge clk);
          if (r == 1) chk(irq_o == 1'b0, "R3 level0 alone", irq_o, 0);
          else chk(irq_o == exp_irq, "R2 irq decision", irq_o, exp_irq);
          if (!exp_irq) begin
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk(!ien_we_o && !pri_we_o && !done_o && !irq_o, "R4 ack ignored",
                ien_we_o, 0);
          end else begin
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk(ien_we_o && !ien_o && !pri_we_o && !irq_o, "R5 mask step",
                {ien_we_o, ien_o}, 2);
            @(negedge clk);
            chk(!ien_we_o && !pri_we_o && !done_o && !irq_o, "R6 identify step",
                {ien_we_o, pri_we_o, done_o}, 0);
            @(negedge clk);
            chk(pri_we_o && ien_we_o && ien_o && done_o && !irq_o, "R7 grant strobes",
                {pri_we_o, ien_we_o, ien_o, done_o}, 15);
            chk(pri_o == LVL_W'(lvl) && done_lvl_o == LVL_W'(lvl), "R8 granted level",
                done_lvl_o, lvl);
            cpu_pri_i = LVL_W'(lvl);
            @(negedge clk);
            chk(!done_o && !irq_o && !pri_we_o, "R10 back to idle", irq_o, 0);
            @(negedge clk);
            chk(irq_o == 1'b0, "R11 held request masked", irq_o, 0);
            cpu_pri_i = '0;
            @(negedge clk);
            chk(irq_o == 1'b1, "R11 held request re-raised", irq_o, 1);
          end
          req_i = '0;
          @(negedge clk);
        end

    for (int p = 0; p < NUM_LVL - 1; p++) begin
      req_i = NUM_LVL'(1) << (NUM_LVL - 1); cpu_pri_i = LVL_W'(p); ien_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      req_i = '0;
      chk(ien_we_o && !ien_o, "R5 mask before abort", ien_o, 0);
      @(negedge clk);
      chk(ien_we_o && ien_o && !pri_we_o && !done_o, "R9 abort restores enable",
          {ien_we_o, ien_o, pri_we_o, done_o}, 12);
      @(negedge clk);
      chk(!ien_we_o && !done_o && !irq_o, "R9 abort idle", irq_o, 0);
    end
    summary();
  end
endmodule